// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Acceptor

This block sits beside a processor core and gathers interrupt requests from the system. Each request carries an 8-bit vector, a 3-bit delivery mode and a level/edge flag. Ordinary requests (fixed and lowest-priority modes) are queued in a 256-entry request bitmap. The highest queued vector is offered to the core only when two things are true. It must rank above the highest vector already in service. Its priority class, the upper four vector bits, must also exceed the class held in a task priority register.

The four special kinds bypass the bitmaps. System management, non-maskable and init requests each have their own latch. External requests have a latch that also captures the vector. The block offers exactly one interrupt at a time through a valid/ack handshake, with its kind and vector. An acknowledge moves a regular vector from "requested" to "in service". A separate end-of-interrupt pulse retires the highest in-service vector, so lower or equal vectors can be offered again.

Top module: `irq_acceptor`

## Requirements
- R1: A request with mode 0 (fixed) or mode 1 (lowest priority) sets the request bit of its vector one cycle later. If that bit is already set, the request is dropped and its level flag does not change the stored trigger mode.
- R2: When a regular request is accepted, its trigger bit is stored as its level flag (1 = level, 0 = edge). `pend_level` shows that bit for the offered regular vector and is 0 for all other kinds.
- R3: Mode 2 (SMI), mode 4 (NMI) and mode 5 (INIT) each set their own pending latch. A repeat request of a kind that is still pending is ignored, so one acknowledge clears it.
- R4: Mode 7 (external) sets the external latch and captures the vector, unless an external request is already pending; in that case the first vector is kept. Modes 3 and 6 are ignored.
- R5: The offered interrupt follows the order SMI, NMI, INIT, external, regular. `pend_kind` codes are 0 none, 1 SMI, 2 NMI, 3 INIT, 4 external, 5 regular. `pend_vector` is 0 for SMI, NMI and INIT, the captured vector for external, and the highest request vector for regular.
- R6: A regular interrupt is offered only if the highest request vector is above the highest in-service vector (taken as 0 when none is in service) and its bits 7:4 are above bits 7:4 of the task priority register.
- R7: Acknowledging a regular interrupt sets its in-service bit and clears its request bit at the same clock edge. `svc_vector` then shows the highest in-service vector, with `svc_any` high.
- R8: Acknowledging a special interrupt clears its latch. The shared unmaskable flag stays set while any of SMI, NMI or INIT remains pending.
- R9: An `eoi` pulse clears the in-service bit of the highest in-service vector. With nothing in service it has no effect.
- R10: External and regular interrupts are offered only while `int_enable` is high. SMI, NMI and INIT are offered regardless of it.
- R11: After a synchronous active-low reset, nothing is pending or in service, and the task priority is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_vector | input | 8 | Request vector |
| req_mode | input | 3 | Delivery mode of the request |
| req_level | input | 1 | 1 = level triggered, 0 = edge |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_data | input | 8 | Task priority write value |
| eoi | input | 1 | End-of-interrupt pulse |
| int_enable | input | 1 | Core interrupt enable for maskable kinds |
| pend_valid | output | 1 | An interrupt is offered |
| pend_kind | output | 3 | Kind of the offered interrupt |
| pend_vector | output | 8 | Vector of the offered interrupt |
| pend_level | output | 1 | Trigger bit of an offered regular vector |
| pend_ack | input | 1 | Core takes the offered interrupt |
| svc_vector | output | 8 | Highest in-service vector |
| svc_any | output | 1 | Some vector is in service |

## Verification
The assertions check several properties on every cycle. An offered regular vector must always clear both the in-service rank and the task class. The unmaskable flag must agree with the three latches. With interrupts disabled, only unmaskable kinds may be offered. An acknowledge or end-of-interrupt must move the bit it names. The bench scenarios are needed for the rest: dropped duplicates, the retained external vector, ignored reserved modes and the full precedence walk. Those depend on the history of requests, and the bench follows that history with a behavioural reference model compared every clock.

// File: rtl/irq_acc_pkg.sv
// Shared encodings for the interrupt acceptor.
// Assumes an 8-bit vector space by default; other modules take widths as parameters.
package irq_acc_pkg;
    localparam int VEC_W   = 8;
    localparam int CLASS_W = 4;
    localparam int KIND_W  = 3;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSV3   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_RSV6   = 3'd6,
        DM_EXT    = 3'd7
    } dmode_e;

    typedef enum logic [KIND_W-1:0] {
        K_NONE = 3'd0,
        K_SMI  = 3'd1,
        K_NMI  = 3'd2,
        K_INIT = 3'd3,
        K_EXT  = 3'd4,
        K_REG  = 3'd5
    } kind_e;
endpackage

// File: rtl/irq_prio_enc.sv
// Highest-set-bit encoder.
// Returns the index of the most significant set bit, and 0 with any_o low when none is set.
module irq_prio_enc #(
    parameter int N  = 256,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    // Scan upward so the last hit is the highest index.
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (bits_i[i]) begin
                idx_o = IW'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_vector_bank.sv
// Request, in-service and trigger-mode bitmaps for regular interrupts.
// Assumes take_i is raised only while the highest request vector is being offered,
// and that the taken vector ranks above every in-service vector.
module irq_vector_bank #(
    parameter int VEC_W = 8,
    localparam int NV   = 1 << VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid_i,
    input  logic [VEC_W-1:0] acc_vec_i,
    input  logic             acc_level_i,
    input  logic             take_i,
    input  logic             eoi_i,
    output logic [VEC_W-1:0] irr_top_o,
    output logic             irr_any_o,
    output logic [VEC_W-1:0] isr_top_o,
    output logic             isr_any_o,
    output logic             top_level_o
);
    logic [NV-1:0] irr_q, isr_q, tmr_q;

    irq_prio_enc #(.N(NV), .IW(VEC_W)) u_irr_enc (
        .bits_i(irr_q), .idx_o(irr_top_o), .any_o(irr_any_o));
    irq_prio_enc #(.N(NV), .IW(VEC_W)) u_isr_enc (
        .bits_i(isr_q), .idx_o(isr_top_o), .any_o(isr_any_o));

    assign top_level_o = tmr_q[irr_top_o];

    // Queue new requests, move acknowledged vectors into service, retire on end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
        end else begin
            if (acc_valid_i && !irr_q[acc_vec_i]) begin
                irr_q[acc_vec_i] <= 1'b1;
                tmr_q[acc_vec_i] <= acc_level_i;
            end
            if (take_i) begin
                isr_q[irr_top_o] <= 1'b1;
                irr_q[irr_top_o] <= 1'b0;
            end
            if (eoi_i && isr_any_o) begin
                isr_q[isr_top_o] <= 1'b0;
            end
        end
    end

    // R1: a duplicate request leaves the stored trigger mode untouched.
    assert_dup_keeps_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && irr_q[acc_vec_i]) |=> (tmr_q[$past(acc_vec_i)] == $past(tmr_q[acc_vec_i])));

    // R7: an acknowledged vector moves from request to in-service.
    assert_take_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (isr_q[$past(irr_top_o)] && !irr_q[$past(irr_top_o)]));

    // R9: end-of-interrupt retires the highest in-service vector.
    assert_eoi_retires_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && isr_any_o) |=> !isr_q[$past(isr_top_o)]);
endmodule

// File: rtl/irq_special_latches.sv
// Pending latches for SMI, NMI, INIT and external requests, plus a shared unmaskable flag.
// Assumes at most one acknowledge strobe is high per cycle.
module irq_special_latches
    import irq_acc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [2:0]       req_mode_i,
    input  logic [VEC_W-1:0] req_vec_i,
    input  logic             ack_smi_i,
    input  logic             ack_nmi_i,
    input  logic             ack_init_i,
    input  logic             ack_ext_i,
    output logic             smi_o,
    output logic             nmi_o,
    output logic             init_o,
    output logic             ext_o,
    output logic [VEC_W-1:0] ext_vec_o,
    output logic             unmask_o
);
    logic             smi_d, nmi_d, init_d, ext_d, unmask_d;
    logic [VEC_W-1:0] ext_vec_d;
    logic             set_unmask;
    dmode_e           mode;

    assign mode = dmode_e'(req_mode_i);

    // Next-state: a request sets a latch only if it is clear, an acknowledge clears it.
    always_comb begin
        smi_d      = smi_o;
        nmi_d      = nmi_o;
        init_d     = init_o;
        ext_d      = ext_o;
        ext_vec_d  = ext_vec_o;
        set_unmask = 1'b0;
        if (req_valid_i) begin
            case (mode)
                DM_SMI:  if (!smi_o)  begin smi_d  = 1'b1; set_unmask = 1'b1; end
                DM_NMI:  if (!nmi_o)  begin nmi_d  = 1'b1; set_unmask = 1'b1; end
                DM_INIT: if (!init_o) begin init_d = 1'b1; set_unmask = 1'b1; end
                DM_EXT:  if (!ext_o)  begin ext_d  = 1'b1; ext_vec_d = req_vec_i; end
                default: ;
            endcase
        end
        if (ack_smi_i)  smi_d  = 1'b0;
        if (ack_nmi_i)  nmi_d  = 1'b0;
        if (ack_init_i) init_d = 1'b0;
        if (ack_ext_i)  ext_d  = 1'b0;
        unmask_d = set_unmask || (unmask_o && (smi_d || nmi_d || init_d));
    end

    // Latch registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_o     <= 1'b0;
            nmi_o     <= 1'b0;
            init_o    <= 1'b0;
            ext_o     <= 1'b0;
            ext_vec_o <= '0;
            unmask_o  <= 1'b0;
        end else begin
            smi_o     <= smi_d;
            nmi_o     <= nmi_d;
            init_o    <= init_d;
            ext_o     <= ext_d;
            ext_vec_o <= ext_vec_d;
            unmask_o  <= unmask_d;
        end
    end

    // R8: the shared flag tracks the three unmaskable latches.
    assert_unmask_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unmask_o == (smi_o || nmi_o || init_o));

    // R4: a pending external request keeps its captured vector.
    assert_ext_vec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_o && !ack_ext_i) |=> (ext_o && $stable(ext_vec_o)));
endmodule

// File: rtl/irq_present_arbiter.sv
// Chooses the single interrupt offered to the core by fixed precedence.
// Assumes its inputs are registered state; this module is purely combinational.
module irq_present_arbiter
    import irq_acc_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int CLASS_W = 4
) (
    input  logic             smi_i,
    input  logic             nmi_i,
    input  logic             init_i,
    input  logic             ext_i,
    input  logic [VEC_W-1:0] ext_vec_i,
    input  logic             int_en_i,
    input  logic             irr_any_i,
    input  logic [VEC_W-1:0] irr_top_i,
    input  logic [VEC_W-1:0] isr_top_i,
    input  logic             top_level_i,
    input  logic [VEC_W-1:0] tpr_i,
    output logic             valid_o,
    output kind_e            kind_o,
    output logic [VEC_W-1:0] vector_o,
    output logic             level_o
);
    logic reg_ok;

    // Regular vector must beat the in-service rank and the task class.
    assign reg_ok = irr_any_i && (irr_top_i > isr_top_i) &&
                    (irr_top_i[VEC_W-1 -: CLASS_W] > tpr_i[VEC_W-1 -: CLASS_W]);

    // Fixed-precedence selection.
    always_comb begin
        kind_o   = K_NONE;
        vector_o = '0;
        level_o  = 1'b0;
        if (smi_i) begin
            kind_o = K_SMI;
        end else if (nmi_i) begin
            kind_o = K_NMI;
        end else if (init_i) begin
            kind_o = K_INIT;
        end else if (int_en_i && ext_i) begin
            kind_o   = K_EXT;
            vector_o = ext_vec_i;
        end else if (int_en_i && reg_ok) begin
            kind_o   = K_REG;
            vector_o = irr_top_i;
            level_o  = top_level_i;
        end
        valid_o = (kind_o != K_NONE);
    end
endmodule

// File: rtl/irq_acceptor.sv
// Top of the interrupt acceptor: task priority register, handshake decode and wiring.
// Assumes pend_ack is only meaningful while pend_valid is high.
module irq_acceptor
    import irq_acc_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int CW = CLASS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [VW-1:0] req_vector,
    input  logic [2:0]    req_mode,
    input  logic          req_level,
    input  logic          tpr_wr,
    input  logic [VW-1:0] tpr_data,
    input  logic          eoi,
    input  logic          int_enable,
    output logic          pend_valid,
    output logic [2:0]    pend_kind,
    output logic [VW-1:0] pend_vector,
    output logic          pend_level,
    input  logic          pend_ack,
    output logic [VW-1:0] svc_vector,
    output logic          svc_any
);
    logic [VW-1:0] tpr_q;
    logic          acc_valid, take;
    logic [VW-1:0] irr_top, isr_top, ext_vec;
    logic          irr_any, isr_any, top_level;
    logic          smi_p, nmi_p, init_p, ext_p, unmask_p;
    logic          ack_smi, ack_nmi, ack_init, ack_ext;
    kind_e         kind;
    logic          fire;

    // Task priority register.
    always_ff @(posedge clk) begin
        if (!rst_n) tpr_q <= '0;
        else if (tpr_wr) tpr_q <= tpr_data;
    end

    assign acc_valid = req_valid &&
                       (req_mode == DM_FIXED || req_mode == DM_LOWEST);
    assign fire      = pend_valid && pend_ack;
    assign take      = fire && (kind == K_REG);
    assign ack_smi   = fire && (kind == K_SMI);
    assign ack_nmi   = fire && (kind == K_NMI);
    assign ack_init  = fire && (kind == K_INIT);
    assign ack_ext   = fire && (kind == K_EXT);

    irq_vector_bank #(.VEC_W(VW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .acc_valid_i(acc_valid), .acc_vec_i(req_vector), .acc_level_i(req_level),
        .take_i(take), .eoi_i(eoi),
        .irr_top_o(irr_top), .irr_any_o(irr_any),
        .isr_top_o(isr_top), .isr_any_o(isr_any),
        .top_level_o(top_level));

    irq_special_latches #(.VEC_W(VW)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_mode_i(req_mode), .req_vec_i(req_vector),
        .ack_smi_i(ack_smi), .ack_nmi_i(ack_nmi), .ack_init_i(ack_init), .ack_ext_i(ack_ext),
        .smi_o(smi_p), .nmi_o(nmi_p), .init_o(init_p), .ext_o(ext_p),
        .ext_vec_o(ext_vec), .unmask_o(unmask_p));

    irq_present_arbiter #(.VEC_W(VW), .CLASS_W(CW)) u_arb (
        .smi_i(smi_p), .nmi_i(nmi_p), .init_i(init_p), .ext_i(ext_p),
        .ext_vec_i(ext_vec), .int_en_i(int_enable),
        .irr_any_i(irr_any), .irr_top_i(irr_top), .isr_top_i(isr_top),
        .top_level_i(top_level), .tpr_i(tpr_q),
        .valid_o(pend_valid), .kind_o(kind), .vector_o(pend_vector), .level_o(pend_level));

    assign pend_kind  = kind;
    assign svc_vector = isr_top;
    assign svc_any    = isr_any;

    // R6: an offered regular vector beats both the in-service rank and the task class.
    assert_reg_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && kind == K_REG) |->
        ((pend_vector > svc_vector) && (pend_vector[VW-1 -: CW] > tpr_q[VW-1 -: CW])));

    // R10: with interrupts disabled only unmaskable kinds are offered.
    assert_mask_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_enable && pend_valid) |-> unmask_p);

    // R5: a pending SMI always wins.
    assert_smi_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        smi_p |-> (pend_valid && kind == K_SMI));

    // R2: the level flag is only driven for regular interrupts.
    assert_level_regular_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != K_REG) |-> !pend_level);
endmodule

// File: tb/irq_acceptor_tb.sv
module irq_acceptor_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic [7:0] req_vector;
    logic [2:0] req_mode;
    logic       req_level;
    logic       tpr_wr;
    logic [7:0] tpr_data;
    logic       eoi;
    logic       int_enable;
    logic       pend_valid;
    logic [2:0] pend_kind;
    logic [7:0] pend_vector;
    logic       pend_level;
    logic       pend_ack;
    logic [7:0] svc_vector;
    logic       svc_any;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_acceptor dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_mode(req_mode), .req_level(req_level), .tpr_wr(tpr_wr), .tpr_data(tpr_data),
        .eoi(eoi), .int_enable(int_enable), .pend_valid(pend_valid), .pend_kind(pend_kind),
        .pend_vector(pend_vector), .pend_level(pend_level), .pend_ack(pend_ack),
        .svc_vector(svc_vector), .svc_any(svc_any));

    // ---------------- behavioural reference model ----------------
    bit m_irr[256];
    bit m_isr[256];
    bit m_tmr[256];
    bit m_smi, m_nmi, m_init, m_ext;
    int m_extv, m_tpr;

    function automatic int top_of(input bit a[256]);
        int r = -1;
        for (int i = 0; i < 256; i++) if (a[i]) r = i;
        return r;
    endfunction

    function automatic void model_out(output bit v, output int k, output int vec,
                                      output bit lv, output int sv, output bit sa);
        int hr = top_of(m_irr);
        int hs = top_of(m_isr);
        int hs0 = (hs < 0) ? 0 : hs;
        k = 0; vec = 0; lv = 0;
        if (m_smi) k = 1;
        else if (m_nmi) k = 2;
        else if (m_init) k = 3;
        else if (int_enable && m_ext) begin k = 4; vec = m_extv; end
        else if (int_enable && hr >= 0 && hr > hs0 && (hr / 16) > (m_tpr / 16)) begin
            k = 5; vec = hr; lv = m_tmr[hr];
        end
        v  = (k != 0);
        sv = hs0;
        sa = (hs >= 0);
    endfunction

    always @(posedge clk) begin
        bit v, lv, sa; int k, vec, sv, hs;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin m_irr[i] = 0; m_isr[i] = 0; m_tmr[i] = 0; end
            m_smi = 0; m_nmi = 0; m_init = 0; m_ext = 0; m_extv = 0; m_tpr = 0;
        end else begin
            model_out(v, k, vec, lv, sv, sa);
            hs = top_of(m_isr);
            if (req_valid) begin
                case (req_mode)
                    3'd0, 3'd1: if (!m_irr[req_vector]) begin
                        m_irr[req_vector] = 1; m_tmr[req_vector] = req_level;
                    end
                    3'd2: m_smi = 1;
                    3'd4: m_nmi = 1;
                    3'd5: m_init = 1;
                    3'd7: if (!m_ext) begin m_ext = 1; m_extv = req_vector; end
                    default: ;
                endcase
            end
            if (v && pend_ack) begin
                case (k)
                    1: m_smi = 0;
                    2: m_nmi = 0;
                    3: m_init = 0;
                    4: m_ext = 0;
                    5: begin m_isr[vec] = 1; m_irr[vec] = 0; end
                    default: ;
                endcase
            end
            if (eoi && hs >= 0) m_isr[hs] = 0;
            if (tpr_wr) m_tpr = tpr_data;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_model();
        bit v, lv, sa; int k, vec, sv;
        model_out(v, k, vec, lv, sv, sa);
        n_run++;
        if (pend_valid !== v || int'(pend_kind) != k || int'(pend_vector) != vec ||
            pend_level !== lv || int'(svc_vector) != sv || svc_any !== sa) begin
            n_fail++;
            $display("FAIL R5/R6 model actual=%0h/%0h/%0h/%0h/%0h/%0h expected=%0h/%0h/%0h/%0h/%0h/%0h",
                     pend_valid, pend_kind, pend_vector, pend_level, svc_vector, svc_any,
                     v, k, vec, lv, sv, sa);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (rst_n) compare_model();
        req_valid = 0; tpr_wr = 0; eoi = 0; pend_ack = 0;
    endtask

    task automatic send(input int mode, input int vec, input bit lvl);
        req_valid = 1; req_mode = 3'(mode); req_vector = 8'(vec); req_level = lvl;
        tick();
    endtask

    task automatic ack();
        pend_ack = 1;
        tick();
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 0; req_vector = 0; req_mode = 0; req_level = 0;
        tpr_wr = 0; tpr_data = 0; eoi = 0; int_enable = 1; pend_ack = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R11: reset state
        chk("R11 valid", pend_valid, 0);
        chk("R11 svc", svc_any, 0);

        // R1/R2: level request at 0x45
        send(0, 8'h45, 1);
        chk("R1 kind", pend_kind, 5);
        chk("R1 vector", pend_vector, 8'h45);
        chk("R2 level", pend_level, 1);

        // R6: task class masking
        tpr_wr = 1; tpr_data = 8'h50; tick();
        chk("R6 tpr mask", pend_valid, 0);
        tpr_wr = 1; tpr_data = 8'h30; tick();
        chk("R6 tpr pass", pend_kind, 5);

        // R10: enable gates regular
        int_enable = 0; tick();
        chk("R10 masked", pend_valid, 0);
        int_enable = 1; tick();

        // R7: acknowledge moves to service
        ack();
        chk("R7 svc", svc_vector, 8'h45);
        chk("R7 none", pend_valid, 0);

        // R6: lower vector blocked by in-service rank (class 4 > tpr class 3 would pass)
        send(1, 8'h42, 0);
        chk("R6 rank", pend_valid, 0);
        send(0, 8'h80, 0);
        chk("R2 edge", pend_level, 0);
        chk("R6 higher", pend_vector, 8'h80);

        // R1: duplicate with level flag dropped
        send(0, 8'h80, 1);
        chk("R1 dup level", pend_level, 0);

        // R7/R9: nested service and retirement
        ack();
        chk("R7 nested", svc_vector, 8'h80);
        eoi = 1; tick();
        chk("R9 eoi1", svc_vector, 8'h45);
        chk("R9 still blocked", pend_valid, 0);
        eoi = 1; tick();
        chk("R9 eoi2", svc_any, 0);
        chk("R9 unblocks", pend_vector, 8'h42);
        eoi = 1; tick();
        chk("R9 idle eoi", pend_vector, 8'h42);

        // R4: external capture, repeat and reserved modes
        send(7, 8'h77, 0);
        chk("R4 ext", pend_kind, 4);
        send(7, 8'h99, 0);
        chk("R4 keep vector", pend_vector, 8'h77);
        send(3, 8'h11, 0);
        send(6, 8'h12, 0);
        chk("R4 reserved", pend_kind, 4);

        // R3/R5: specials and precedence
        send(5, 0, 0);
        chk("R5 init over ext", pend_kind, 3);
        send(4, 0, 0);
        send(4, 0, 0);
        chk("R5 nmi over init", pend_kind, 2);
        send(2, 0, 0);
        chk("R5 smi first", pend_kind, 1);
        chk("R5 smi vector", pend_vector, 0);
        int_enable = 0; tick();
        chk("R10 smi unmasked", pend_kind, 1);
        ack();
        chk("R8 smi cleared", pend_kind, 2);
        ack();
        chk("R3 single nmi", pend_kind, 3);
        ack();
        chk("R10 ext masked", pend_valid, 0);
        int_enable = 1; tick();
        chk("R8 ext shown", pend_vector, 8'h77);
        ack();
        chk("R5 regular last", pend_kind, 5);
        ack();
        chk("R7 final svc", svc_vector, 8'h42);

        // R3: repeat request while pending is ignored
        send(2, 0, 0);
        send(2, 0, 0);
        ack();
        chk("R3 smi once", pend_valid, 0);
        repeat (4) tick();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule